// File: doc/BRIEF.md
# Parity-checked register-access serial slave

This block is the serial front end of a sensor die. A host is the master on a four-wire serial bus (clock idle low). It exchanges fixed 16-bit frames with the block. Every frame, in either direction, carries even parity over all 16 bits. A command frame names a register and a direction. The block decodes it once slave select rises and answers in the next frame, so the host always receives the reply to the command it sent one frame earlier. A write takes two frames: the command frame, then a data frame.

The block holds a small register set: a 6-bit gain value, an 8-bit power-on-reset disable key and two configuration bits. It also exposes a read-only angle word, built from the 10-bit angle and the two field alarms that the measurement path drives onto input ports. A sticky error flag records malformed traffic and travels in every reply frame until the host clears it. Reading the angle pulses a strobe that the measurement controller uses to drop its interrupt and start the next conversion. A software-reset command returns the configuration to its defaults and pulses a second strobe.

The bus pins are sampled by `clk_i`, which must run several times faster than the serial clock. Any synchronizers belong outside the block.

Top module: `spi_reg_slave`

## Requirements
- R1: A frame is 16 bits, MSB first. While `ss_ni` is low, MOSI is sampled on each falling edge of `sck_i`, and `miso_o` moves to the next reply bit on each rising edge. `miso_o` is 0 while the block is deselected.
- R2: In a command frame, bit 15 is the direction (1 = read), bits 14:1 are the address and bit 0 is parity. In a reply frame, bits 15:2 are data, bit 1 is the error flag and bit 0 is parity. In both, bit 0 makes the frame even parity.
- R3: The reply to frame N is shifted out in frame N+1. Its data is taken from the registers at the falling edge of `ss_ni` that opens frame N+1. The first frame after reset returns 0x0000. This holds even when slave select stays high for only one clock between frames.
- R4: A write is a command frame (bit 15 = 0) followed by a data frame whose bits 15:2 are the value; bit 1 of the data frame is ignored. The reply during the data frame is the old contents, and the reply in the frame after it is the new contents. The writable registers are: gain at 0x3FF8 (bits 5:0, reset 0x20), key at 0x3F22 (bits 7:0, reset 0) and configuration at 0x3F20 (bit 1 = break offset loop, bit 0 = interrupt gate mode, reset 0).
- R5: A read of 0x3FFF returns the angle word: `angle_i` in bits 9:0, zeros in bits 11:10, `alarm_lo_i` in bit 12 and `alarm_hi_i` in bit 13. Each decoded read of 0x3FFF pulses `angle_read_o` for one clock.
- R6: The error flag is set by any of: a command with bad parity; an unknown command; or a frame closed after a bit count other than 16. An unknown command is a write to any address other than 0x0000, 0x3F20, 0x3F22, 0x3FF8 or 0x3C00, or a read of any address other than 0x0000, 0x3F20, 0x3F22, 0x3FF8, 0x3FFF or 0x3380. A miscounted frame is discarded and cancels a pending write. The flag stays set until it is cleared.
- R7: A read of 0x3380 clears the error flag and returns data 0. A write command to 0x0000 (the all-zero frame) is a no-op and returns data 0. Any reply with data 0 still carries the current error flag in bit 1.
- R8: A software reset is a write command to 0x3C00 followed by a data frame. On the data frame, gain, key and configuration return to their reset values, `soft_reset_o` pulses for one clock and the next reply has data 0. If bit 2 of that data frame is 1, the error flag is also cleared; otherwise the flag keeps its value.
- R9: `por_off_o` is high exactly while the key register holds 0x5A.
- R10: A data frame with bad parity performs no write or reset, sets the error flag and ends the pending write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, oversamples the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock, idle low |
| ss_ni | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| angle_i | input | 10 | Latest measured angle |
| alarm_lo_i | input | 1 | Field too weak |
| alarm_hi_i | input | 1 | Field too strong |
| angle_read_o | output | 1 | One-clock pulse on a decoded angle read |
| soft_reset_o | output | 1 | One-clock pulse on a software reset |
| agc_o | output | 6 | Gain register |
| por_off_o | output | 1 | Power-on-reset cell disabled |
| int_mode_o | output | 1 | Interrupt gate mode bit |
| brk_offset_o | output | 1 | Break offset loop bit |

## Verification
The tight case is the decode of frame N, which happens on the clock where slave select rises, against the reply load for frame N+1, which happens on the clock where it falls again. With a one-clock deselect gap these land on adjacent edges, so a late decode would show up as a stale reply. The bench runs a burst of frames with a single-clock gap and checks each reply against a model that updates before the next frame starts. A second overlap is a clear command that carries bad parity: the flag must stay set. This is judged by reading the flag bit in the following reply.

// File: rtl/spi_reg_slave_pkg.sv
package spi_reg_slave_pkg;
  localparam int FRAME_W = 16;
  localparam int WORD_W  = FRAME_W - 2;
  typedef logic [WORD_W-1:0] word_t;

  localparam word_t ADDR_NOP   = 14'h0000;
  localparam word_t ADDR_CLR   = 14'h3380;
  localparam word_t ADDR_SRST  = 14'h3C00;
  localparam word_t ADDR_CFG   = 14'h3F20;
  localparam word_t ADDR_KEY   = 14'h3F22;
  localparam word_t ADDR_AGC   = 14'h3FF8;
  localparam word_t ADDR_ANGLE = 14'h3FFF;

  localparam logic [7:0] POR_KEY = 8'h5A;
  localparam int RES_SPI_BIT  = 0;   // data bit 0 = frame bit 2
  localparam int ALM_LO_BIT   = 12;
  localparam int ALM_HI_BIT   = 13;
  localparam int CFG_GATE_BIT = 0;
  localparam int CFG_BRK_BIT  = 1;

  function automatic logic is_readable(word_t a);
    return (a == ADDR_ANGLE) || (a == ADDR_AGC) || (a == ADDR_KEY) ||
           (a == ADDR_CFG) || (a == ADDR_NOP);
  endfunction

  function automatic logic is_writable(word_t a);
    return (a == ADDR_AGC) || (a == ADDR_KEY) || (a == ADDR_CFG) || (a == ADDR_SRST);
  endfunction

  function automatic logic [FRAME_W-1:0] mk_reply(word_t d, logic e);
    return {d, e, ^{d, e}};
  endfunction
endpackage

// File: rtl/spi_reg_slave_shift.sv
module spi_reg_slave_shift
  import spi_reg_slave_pkg::*;
#(
  parameter int CNT_W = $clog2(FRAME_W) + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sck_i,
  input  logic               ss_ni,
  input  logic               mosi_i,
  input  logic [FRAME_W-1:0] tx_word_i,
  output logic               miso_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               frame_ok_o,
  output logic               frame_bad_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  logic sck_q, ss_q, miso_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] rx_q, tx_q;
  logic ss_fall, ss_rise, sck_fall, sck_rise;

  assign ss_fall  = ss_q & ~ss_ni;
  assign ss_rise  = ~ss_q & ss_ni;
  assign sck_fall = ~ss_ni & sck_q & ~sck_i;
  assign sck_rise = ~ss_ni & ~sck_q & sck_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q  <= 1'b0;
      ss_q   <= 1'b1;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      miso_q <= 1'b0;
    end else begin
      sck_q <= sck_i;
      ss_q  <= ss_ni;
      if (ss_fall) begin
        cnt_q  <= '0;
        tx_q   <= tx_word_i;
        miso_q <= 1'b0;
      end else begin
        if (sck_fall) begin
          rx_q <= {rx_q[FRAME_W-2:0], mosi_i};
          if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;  // saturate on runaway clocks
        end
        if (sck_rise) begin
          miso_q <= tx_q[FRAME_W-1];
          tx_q   <= {tx_q[FRAME_W-2:0], 1'b0};
        end
      end
      if (ss_rise) miso_q <= 1'b0;
    end
  end

  assign miso_o      = miso_q;
  assign frame_o     = rx_q;
  assign frame_ok_o  = ss_rise & (cnt_q == FULL);
  assign frame_bad_o = ss_rise & (cnt_q != FULL);

  // R1: output is quiet while deselected
  a_r1_idle_miso: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_q && ss_ni) |-> !miso_q);

  // R2: every reply loaded for shifting has even parity
  a_r2_tx_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_fall |=> !(^tx_q));
endmodule

// File: rtl/spi_reg_slave_regs.sv
module spi_reg_slave_regs
  import spi_reg_slave_pkg::*;
#(
  parameter int              ANGLE_W = 10,
  parameter int              AGC_W   = 6,
  parameter int              KEY_W   = 8,
  parameter logic [AGC_W-1:0] AGC_RST = 'h20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  word_t              wr_addr_i,
  input  word_t              wr_data_i,
  input  logic               soft_rst_i,
  input  word_t              rd_addr_i,
  output word_t              rd_data_o,
  input  logic [ANGLE_W-1:0] angle_i,
  input  logic               alarm_lo_i,
  input  logic               alarm_hi_i,
  output logic [AGC_W-1:0]   agc_o,
  output logic               por_off_o,
  output logic               int_mode_o,
  output logic               brk_offset_o
);
  logic [AGC_W-1:0] agc_q;
  logic [KEY_W-1:0] key_q;
  logic [1:0]       cfg_q;
  logic             unused_hi_data;

  assign unused_hi_data = ^wr_data_i[WORD_W-1:KEY_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      agc_q <= AGC_RST;
      key_q <= '0;
      cfg_q <= '0;
    end else if (soft_rst_i) begin
      agc_q <= AGC_RST;
      key_q <= '0;
      cfg_q <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADDR_AGC: agc_q <= wr_data_i[AGC_W-1:0];
        ADDR_KEY: key_q <= wr_data_i[KEY_W-1:0];
        ADDR_CFG: cfg_q <= wr_data_i[1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      ADDR_ANGLE: begin
        rd_data_o[ANGLE_W-1:0] = angle_i;
        rd_data_o[ALM_LO_BIT]  = alarm_lo_i;
        rd_data_o[ALM_HI_BIT]  = alarm_hi_i;
      end
      ADDR_AGC: rd_data_o[AGC_W-1:0] = agc_q;
      ADDR_KEY: rd_data_o[KEY_W-1:0] = key_q;
      ADDR_CFG: rd_data_o[1:0]       = cfg_q;
      default: ;
    endcase
  end

  assign agc_o        = agc_q;
  assign por_off_o    = (key_q == KEY_W'(POR_KEY));
  assign int_mode_o   = cfg_q[CFG_GATE_BIT];
  assign brk_offset_o = cfg_q[CFG_BRK_BIT];

  // R8: software reset restores every configuration default
  a_r8_srst_defaults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (agc_q == AGC_RST) && (key_q == '0) && (cfg_q == '0));

  // R9: the disable flag only appears as the result of a write
  a_r9_key_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(por_off_o) |-> $past(wr_en_i));
endmodule

// File: rtl/spi_reg_slave_ctrl.sv
module spi_reg_slave_ctrl
  import spi_reg_slave_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               frame_ok_i,
  input  logic               frame_bad_i,
  output logic               wr_en_o,
  output word_t              wr_addr_o,
  output word_t              wr_data_o,
  output logic               soft_rst_o,
  output word_t              reply_addr_o,
  output logic               err_o,
  output logic               angle_read_o,
  output logic               soft_reset_o
);
  logic  pend_q, pend_d, err_q, err_set, err_clr;
  logic  ang_rd, ang_rd_q, srst_q;
  word_t pend_addr_q, pend_addr_d, reply_addr_q, reply_addr_d;
  logic  rw, par_ok;
  word_t addr, data;

  assign rw     = frame_i[FRAME_W-1];
  assign addr   = frame_i[FRAME_W-2:1];
  assign data   = frame_i[FRAME_W-1:2];
  assign par_ok = ~^frame_i;

  always_comb begin
    pend_d       = pend_q;
    pend_addr_d  = pend_addr_q;
    reply_addr_d = reply_addr_q;
    err_set      = 1'b0;
    err_clr      = 1'b0;
    wr_en_o      = 1'b0;
    soft_rst_o   = 1'b0;
    ang_rd       = 1'b0;
    if (frame_bad_i) begin
      err_set      = 1'b1;
      pend_d       = 1'b0;
      reply_addr_d = ADDR_NOP;
    end else if (frame_ok_i) begin
      reply_addr_d = ADDR_NOP;
      if (pend_q) begin
        pend_d = 1'b0;
        if (!par_ok) begin
          err_set = 1'b1;
        end else if (pend_addr_q == ADDR_SRST) begin
          soft_rst_o = 1'b1;
          err_clr    = data[RES_SPI_BIT];
        end else begin
          wr_en_o      = 1'b1;
          reply_addr_d = pend_addr_q;
        end
      end else if (!par_ok) begin
        err_set = 1'b1;
      end else if (rw) begin
        if (addr == ADDR_CLR) begin
          err_clr = 1'b1;
        end else if (is_readable(addr)) begin
          reply_addr_d = addr;
          ang_rd       = (addr == ADDR_ANGLE);
        end else begin
          err_set = 1'b1;
        end
      end else if (addr != ADDR_NOP) begin
        if (is_writable(addr)) begin
          pend_d       = 1'b1;
          pend_addr_d  = addr;
          reply_addr_d = addr;
        end else begin
          err_set = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q       <= 1'b0;
      pend_addr_q  <= ADDR_NOP;
      reply_addr_q <= ADDR_NOP;
      err_q        <= 1'b0;
      ang_rd_q     <= 1'b0;
      srst_q       <= 1'b0;
    end else begin
      pend_q       <= pend_d;
      pend_addr_q  <= pend_addr_d;
      reply_addr_q <= reply_addr_d;
      ang_rd_q     <= ang_rd;
      srst_q       <= soft_rst_o;
      if (err_set)      err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  assign wr_addr_o    = pend_addr_q;
  assign wr_data_o    = data;
  assign reply_addr_o = reply_addr_q;
  assign err_o        = err_q;
  assign angle_read_o = ang_rd_q;
  assign soft_reset_o = srst_q;

  // R6: the flag can only drop after a complete frame
  a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !frame_ok_i) |=> err_q);
  // R6: a miscounted frame always leaves the flag set
  a_r6_bad_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_bad_i |=> err_q);
  // R2: odd parity on any complete frame sets the flag
  a_r2_parity_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_ok_i && ^frame_i) |=> err_q);
  // R4: a write consumes exactly one data frame
  a_r4_one_data_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_ok_i && pend_q) |=> !pend_q);
  // R5: angle strobe lasts a single clock
  a_r5_strobe_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ang_rd_q |=> !ang_rd_q);
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_slave_pkg::*;
#(
  parameter int ANGLE_W = 10,
  parameter int AGC_W   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sck_i,
  input  logic               ss_ni,
  input  logic               mosi_i,
  output logic               miso_o,
  input  logic [ANGLE_W-1:0] angle_i,
  input  logic               alarm_lo_i,
  input  logic               alarm_hi_i,
  output logic               angle_read_o,
  output logic               soft_reset_o,
  output logic [AGC_W-1:0]   agc_o,
  output logic               por_off_o,
  output logic               int_mode_o,
  output logic               brk_offset_o
);
  logic [FRAME_W-1:0] frame, tx_word;
  logic  frame_ok, frame_bad, wr_en, soft_rst, err;
  word_t wr_addr, wr_data, reply_addr, rd_data;

  assign tx_word = mk_reply(rd_data, err);

  spi_reg_slave_shift u_shift (
    .clk_i, .rst_ni, .sck_i, .ss_ni, .mosi_i,
    .tx_word_i  (tx_word),
    .miso_o,
    .frame_o    (frame),
    .frame_ok_o (frame_ok),
    .frame_bad_o(frame_bad)
  );

  spi_reg_slave_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .frame_i     (frame),
    .frame_ok_i  (frame_ok),
    .frame_bad_i (frame_bad),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .soft_rst_o  (soft_rst),
    .reply_addr_o(reply_addr),
    .err_o       (err),
    .angle_read_o,
    .soft_reset_o
  );

  spi_reg_slave_regs #(.ANGLE_W(ANGLE_W), .AGC_W(AGC_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .soft_rst_i(soft_rst),
    .rd_addr_i (reply_addr),
    .rd_data_o (rd_data),
    .angle_i, .alarm_lo_i, .alarm_hi_i,
    .agc_o, .por_off_o, .int_mode_o, .brk_offset_o
  );
endmodule

// File: tb/spi_reg_slave_test.sv
`timescale 1ns/1ps
module spi_reg_slave_test;
  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic [9:0] angle = '0;
  logic alo = 1'b0, ahi = 1'b0;
  logic miso, ang_rd, srst, por_off, int_mode, brk;
  logic [5:0] agc;

  spi_reg_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .ss_ni(ss_n), .mosi_i(mosi),
    .miso_o(miso), .angle_i(angle), .alarm_lo_i(alo), .alarm_hi_i(ahi),
    .angle_read_o(ang_rd), .soft_reset_o(srst), .agc_o(agc),
    .por_off_o(por_off), .int_mode_o(int_mode), .brk_offset_o(brk)
  );

  always #4 clk = ~clk;

  int vectors = 0, fails = 0;
  bit chk_en = 0;
  logic [5:0]  m_agc = 6'h20;
  logic [7:0]  m_key = 8'h00;
  logic [1:0]  m_cfg = 2'b00;
  bit          m_err = 0, m_pend = 0;
  logic [13:0] m_paddr = '0, m_raddr = '0;
  int m_rd = 0, m_sr = 0, cnt_rd = 0, cnt_sr = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  function automatic logic [13:0] m_read(input logic [13:0] a);
    case (a)
      14'h3FFF: return {ahi, alo, 2'b00, angle};
      14'h3FF8: return {8'h00, m_agc};
      14'h3F22: return {6'h00, m_key};
      14'h3F20: return {12'h000, m_cfg};
      default:  return 14'h0000;
    endcase
  endfunction

  function automatic logic [15:0] cmd(input bit rd, input logic [13:0] a);
    logic [15:0] w;
    w = {rd, a, 1'b0};
    w[0] = ^w[15:1];
    return w;
  endfunction

  function automatic logic [15:0] dat(input logic [13:0] d, input bit b1);
    logic [15:0] w;
    w = {d, b1, 1'b0};
    w[0] = ^w[15:1];
    return w;
  endfunction

  task automatic m_decode(input logic [15:0] w, input bit full);
    logic [13:0] a;
    a = w[14:1];
    if (!full) begin
      m_err = 1; m_pend = 0; m_raddr = 0;
      return;
    end
    m_raddr = 0;
    if (m_pend) begin
      m_pend = 0;
      if (^w) m_err = 1;
      else if (m_paddr == 14'h3C00) begin
        m_agc = 6'h20; m_key = 0; m_cfg = 0; m_sr++;
        if (w[2]) m_err = 0;
      end else begin
        case (m_paddr)
          14'h3FF8: m_agc = w[7:2];
          14'h3F22: m_key = w[9:2];
          14'h3F20: m_cfg = w[3:2];
          default: ;
        endcase
        m_raddr = m_paddr;
      end
    end else if (^w) m_err = 1;
    else if (w[15]) begin
      case (a)
        14'h3380: m_err = 0;
        14'h3FFF: begin m_raddr = a; m_rd++; end
        14'h3FF8, 14'h3F22, 14'h3F20, 14'h0000: m_raddr = a;
        default: m_err = 1;
      endcase
    end else begin
      case (a)
        14'h0000: ;
        14'h3FF8, 14'h3F22, 14'h3F20, 14'h3C00: begin m_pend = 1; m_paddr = a; m_raddr = a; end
        default: m_err = 1;
      endcase
    end
  endtask

  // called at a negedge; gap = clocks with ss high after the frame
  task automatic xfer(input logic [15:0] w, input int nbits, input int gap, input string tag);
    logic [13:0] d;
    logic [15:0] exp, got;
    d = m_read(m_raddr);
    exp = {d, m_err, ^{d, m_err}};
    got = '0;
    chk_en = 0;
    ss_n = 0;
    repeat (2) @(negedge clk);
    chk("R5 angle strobe count", cnt_rd, m_rd);
    chk("R8 reset strobe count", cnt_sr, m_sr);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? w[15-i] : 1'b0;
      sck = 1;
      repeat (3) @(negedge clk);
      if (i < 16) got[15-i] = miso;
      sck = 0;
      repeat (3) @(negedge clk);
    end
    ss_n = 1;
    mosi = 0;
    repeat (gap) @(negedge clk);
    if (nbits == 16) chk(tag, got, exp);
    m_decode(w, nbits == 16);
    chk_en = 1;
  endtask

  always @(posedge clk) if (rst_n) begin
    if (ang_rd) cnt_rd++;
    if (srst) cnt_sr++;
  end

  always begin
    @(posedge clk);
    #2;
    if (chk_en) begin
      chk("R1 idle miso", miso, 0);
      chk("R4 gain port", agc, m_agc);
      chk("R9 key disable", por_off, m_key == 8'h5A);
      chk("R4 gate mode", int_mode, m_cfg[0]);
      chk("R4 break offset", brk, m_cfg[1]);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset miso", miso, 0);
    chk("R4 reset gain", agc, 6'h20);
    chk("R9 reset key", por_off, 0);
    chk_en = 1;
    angle = 10'h155; alo = 1;
    xfer(cmd(1, 14'h3FFF), 16, 3, "R3 first reply");
    xfer(cmd(0, 14'h0000), 16, 3, "R5 angle reply");
    xfer(cmd(0, 14'h3FF8), 16, 3, "R7 nop reply");
    xfer(dat(14'h15, 1), 16, 3, "R4 old gain");
    xfer(cmd(0, 14'h3F22), 16, 3, "R4 new gain");
    xfer(dat(14'h5A, 0), 16, 3, "R9 old key");
    xfer(cmd(0, 14'h3F20), 16, 3, "R9 new key");
    xfer(dat(14'h3, 0), 16, 3, "R4 old cfg");
    xfer(cmd(1, 14'h3F20), 16, 3, "R4 new cfg");
    xfer(cmd(1, 14'h3FFF) ^ 16'h1, 16, 3, "R4 cfg read");
    xfer(cmd(0, 14'h0000), 16, 3, "R2 parity error reply");
    xfer(cmd(1, 14'h3380) ^ 16'h1, 16, 3, "R6 sticky");
    xfer(cmd(1, 14'h3380), 16, 3, "R6 bad clear ignored");
    xfer(cmd(0, 14'h0000), 16, 3, "R7 clear reply");
    xfer(cmd(0, 14'h0000), 10, 3, "R6");
    xfer(cmd(1, 14'h3380), 16, 3, "R6 short frame flagged");
    xfer(cmd(0, 14'h0000), 18, 3, "R6");
    xfer(cmd(0, 14'h3FF8), 16, 3, "R6 long frame flagged");
    xfer(cmd(0, 14'h0000), 6, 3, "R6");
    xfer(dat(14'h3F, 0), 16, 3, "R6 cancelled write");
    xfer(cmd(1, 14'h3380), 16, 3, "R6 before clear");
    xfer(cmd(1, 14'h3F22), 16, 3, "R7 cleared");
    xfer(cmd(0, 14'h3FFF), 16, 3, "R9 key read");
    xfer(cmd(1, 14'h3380), 16, 3, "R6 write to angle rejected");
    xfer(cmd(0, 14'h3FF8), 16, 3, "R7 clear after reject");
    xfer(dat(14'h2A, 0) ^ 16'h1, 16, 3, "R10 old gain");
    xfer(cmd(1, 14'h3FF8), 16, 3, "R10 bad data flagged");
    xfer(cmd(0, 14'h3C00), 16, 3, "R10 gain kept");
    xfer(dat(14'h0, 0), 16, 3, "R8 reset cmd reply");
    xfer(cmd(0, 14'h0000), 16, 3, "R8 reset data reply");
    xfer(cmd(1, 14'h3FF8), 16, 3, "R8 flag kept");
    xfer(cmd(0, 14'h3C00), 16, 3, "R8 default gain");
    xfer(dat(14'h1, 0), 16, 3, "R8 second reset cmd");
    xfer(cmd(0, 14'h0000), 16, 3, "R8 second reset data");
    angle = 10'h2C3; ahi = 1;
    xfer(cmd(1, 14'h3FFF), 16, 1, "R8 flag cleared by reset");
    xfer(cmd(1, 14'h3F20), 16, 1, "R5 both alarms");
    xfer(cmd(1, 14'h3C00), 16, 1, "R3 one clock gap");
    xfer(cmd(0, 14'h0000), 16, 3, "R6 read unlisted");
    xfer(cmd(1, 14'h3380), 16, 3, "R6 flag before clear");
    xfer(cmd(0, 14'h0000), 16, 3, "R7 final clear");
    repeat (4) @(negedge clk);
    chk("R5 final angle strobes", cnt_rd, m_rd);
    chk("R8 final reset strobes", cnt_sr, m_sr);
    finish_run();
  end
endmodule